// File: doc/BRIEF.md
# STN Frame Rate Control Ditherer

This block turns 4-bit pixel intensities into the single on/off bit per pixel that a passive-matrix STN panel can show. It uses frame rate control: over a fixed cycle of 16 frames, a pixel at a given level is lit in a chosen subset of those frames. The fraction of lit frames sets the brightness the eye perceives. Each level has its own programmable 16-bit pattern mask, and each mask bit stands for one phase of the cycle.

The phase used for a pixel is the frame counter plus the pixel's horizontal coordinate, taken modulo 16. Horizontally neighbouring pixels therefore sit at different points of their pattern, and the whole picture moves one phase every frame. This cuts the flicker that appears when adjacent pixels switch together. In monochrome mode only the red channel is dithered. In colour mode red, green and blue are dithered separately, all with the same phase. When the panel is a TFT, pixel data passes through untouched.

Pattern writes go first to a shadow copy. They reach the working copy at the next frame-start pulse, so a frame is never drawn with a mix of old and new patterns.

Top module: `stn_frc_dither`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `out_valid` is 0 and `out_r`, `out_g`, `out_b` are all 0.
- R2: The internal frame phase is 0 after reset. It advances by one on each cycle with `frame_start` high and wraps from 15 to 0. Without `frame_start` it holds.
- R3: For a dithered channel at level L (1 to 14) and coordinate x, the output bit is bit `(frame + x) mod 16` of the working mask for level L.
- R4: Level 0 always gives 0 and level 15 always gives 1, whatever their masks hold.
- R5: A write (`pat_wr_en` high, with `pat_wr_level` and `pat_wr_mask`) does not change the output until the next `frame_start` cycle. After that cycle the new mask is used.
- R6: With `mode` = 0 (TFT), each output channel equals the matching input channel unchanged.
- R7: With `mode` = 1 (STN mono), `out_r` = {3'b000, red dither bit}, and `out_g` and `out_b` are 0.
- R8: With `mode` = 2 or 3 (STN colour), each of the three channels carries its own dither bit in bit 0, with zeros above it. All three use the same phase.
- R9: Outputs are registered. `out_valid` equals `pix_valid` from the previous cycle, and the data outputs are 0 whenever `out_valid` is 0.
- R10: After reset, the working and shadow masks of level L have bits 0 to L-1 set and all other bits clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_start | input | 1 | One-cycle pulse at the start of each frame |
| mode | input | 2 | 0 TFT bypass, 1 STN mono, 2/3 STN colour |
| pat_wr_en | input | 1 | Pattern mask write strobe |
| pat_wr_level | input | 4 | Level whose mask is written |
| pat_wr_mask | input | 16 | Mask value, bit p is phase p |
| pix_valid | input | 1 | Pixel input valid |
| pix_x | input | 11 | Horizontal pixel coordinate |
| pix_r | input | 4 | Red (or gray) level |
| pix_g | input | 4 | Green level |
| pix_b | input | 4 | Blue level |
| out_valid | output | 1 | Output valid, one cycle after input |
| out_r | output | 4 | Red result (dither bit in bit 0 for STN) |
| out_g | output | 4 | Green result |
| out_b | output | 4 | Blue result |

## Verification
Directed pixels at fixed coordinates step through all 16 frame phases after a single-bit mask is loaded. This shows whether the frame and the coordinate are added or just one is used, and whether the wrap lands on phase 0. The extreme levels are driven against all-ones and all-zeros masks, which separates the forced behaviour from mask lookup. A write followed by pixels before and after a frame pulse checks when the shadow copy takes over. Random pixels with three independent levels in every mode, mixed with random writes and frame pulses, catch channel swaps, mono-mode leakage into green and blue, and bypass corruption.

// File: rtl/frc_pkg.sv
package frc_pkg;
    localparam int LVL_W = 4;
    localparam int NLVL  = 1 << LVL_W;
    localparam int CYCLE = 16;
    localparam int PH_W  = $clog2(CYCLE);
    localparam int X_W   = 11;

    typedef enum logic [1:0] {
        MODE_TFT   = 2'd0,
        MODE_MONO  = 2'd1,
        MODE_COLOR = 2'd2,
        MODE_COLX  = 2'd3
    } disp_mode_e;

    typedef struct packed {
        logic [LVL_W-1:0] r;
        logic [LVL_W-1:0] g;
        logic [LVL_W-1:0] b;
    } rgb_t;

    function automatic logic [CYCLE-1:0] default_mask(int lvl);
        logic [CYCLE-1:0] m;
        m = '0;
        for (int i = 0; i < CYCLE; i++) begin
            if (i < lvl) m[i] = 1'b1;
        end
        return m;
    endfunction

    function automatic logic [PH_W-1:0] pixel_phase(logic [PH_W-1:0] frm,
                                                    logic [X_W-1:0]  x);
        logic [X_W:0] s;
        s = {1'b0, x} + (X_W+1)'(frm);
        return PH_W'(s % (X_W+1)'(CYCLE));
    endfunction
endpackage

// File: rtl/frc_frame_phase.sv
module frc_frame_phase
    import frc_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            frame_start,
    output logic [PH_W-1:0] frame_cnt
);
    always_ff @(posedge clk) begin
        if (rst) begin
            frame_cnt <= '0;
        end else if (frame_start) begin
            if (frame_cnt == PH_W'(CYCLE-1)) frame_cnt <= '0;
            else                             frame_cnt <= frame_cnt + 1'b1;
        end
    end

    // R2: wrap after the last phase
    a_r2_wrap: assert property (@(posedge clk) disable iff (rst)
        (frame_start && frame_cnt == PH_W'(CYCLE-1)) |=> frame_cnt == '0);
    // R2: hold without a frame pulse
    a_r2_hold: assert property (@(posedge clk) disable iff (rst)
        !frame_start |=> $stable(frame_cnt));
endmodule

// File: rtl/frc_pattern_bank.sv
module frc_pattern_bank
    import frc_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        frame_start,
    input  logic                        wr_en,
    input  logic [LVL_W-1:0]            wr_lvl,
    input  logic [CYCLE-1:0]            wr_mask,
    output logic [NLVL-1:0][CYCLE-1:0]  active
);
    logic [NLVL-1:0][CYCLE-1:0] shadow;

    for (genvar g = 0; g < NLVL; g++) begin : g_lvl
        always_ff @(posedge clk) begin
            if (rst) begin
                shadow[g] <= default_mask(g);
                active[g] <= default_mask(g);
            end else begin
                if (wr_en && wr_lvl == LVL_W'(g)) shadow[g] <= wr_mask;
                if (frame_start)                  active[g] <= shadow[g];
            end
        end

        // R5: working copy takes the shadow at a frame pulse
        a_r5_load: assert property (@(posedge clk) disable iff (rst)
            frame_start |=> active[g] == $past(shadow[g]));
    end

    // R5: working copy never changes between frame pulses
    a_r5_active_stable: assert property (@(posedge clk) disable iff (rst)
        !frame_start |=> $stable(active));
endmodule

// File: rtl/frc_channel_dither.sv
module frc_channel_dither
    import frc_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst,
    input  logic [LVL_W-1:0]           lvl,
    input  logic [PH_W-1:0]            phase,
    input  logic [NLVL-1:0][CYCLE-1:0] active,
    output logic                       on
);
    always_comb begin
        if (lvl == '0)                        on = 1'b0;
        else if (lvl == LVL_W'(NLVL-1))       on = 1'b1;
        else                                  on = active[lvl][phase];
    end

    // R4: extreme levels ignore the masks
    a_r4_lvl0_off: assert property (@(posedge clk) disable iff (rst)
        (lvl == '0) |-> !on);
    a_r4_lvlmax_on: assert property (@(posedge clk) disable iff (rst)
        (lvl == LVL_W'(NLVL-1)) |-> on);
endmodule

// File: rtl/stn_frc_dither.sv
module stn_frc_dither
    import frc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_start,
    input  logic [1:0]        mode,
    input  logic              pat_wr_en,
    input  logic [LVL_W-1:0]  pat_wr_level,
    input  logic [CYCLE-1:0]  pat_wr_mask,
    input  logic              pix_valid,
    input  logic [X_W-1:0]    pix_x,
    input  logic [LVL_W-1:0]  pix_r,
    input  logic [LVL_W-1:0]  pix_g,
    input  logic [LVL_W-1:0]  pix_b,
    output logic              out_valid,
    output logic [LVL_W-1:0]  out_r,
    output logic [LVL_W-1:0]  out_g,
    output logic [LVL_W-1:0]  out_b
);
    localparam int NCH = 3;

    logic [PH_W-1:0]            frame_cnt;
    logic [PH_W-1:0]            phase;
    logic [NLVL-1:0][CYCLE-1:0] active;
    logic [NCH-1:0][LVL_W-1:0]  ch_lvl;
    logic [NCH-1:0]             ch_on;
    rgb_t                       pix_in, nxt, out_q;
    disp_mode_e                 mode_e;

    frc_frame_phase i_phase (
        .clk         (clk),
        .rst         (rst),
        .frame_start (frame_start),
        .frame_cnt   (frame_cnt)
    );

    frc_pattern_bank i_bank (
        .clk         (clk),
        .rst         (rst),
        .frame_start (frame_start),
        .wr_en       (pat_wr_en),
        .wr_lvl      (pat_wr_level),
        .wr_mask     (pat_wr_mask),
        .active      (active)
    );

    assign phase  = pixel_phase(frame_cnt, pix_x);
    assign pix_in = '{r: pix_r, g: pix_g, b: pix_b};
    assign ch_lvl = {pix_r, pix_g, pix_b};
    assign mode_e = disp_mode_e'(mode);

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        frc_channel_dither i_ch (
            .clk    (clk),
            .rst    (rst),
            .lvl    (ch_lvl[c]),
            .phase  (phase),
            .active (active),
            .on     (ch_on[c])
        );
    end

    always_comb begin
        nxt = '0;
        if (pix_valid) begin
            unique case (mode_e)
                MODE_TFT:  nxt = pix_in;
                MODE_MONO: nxt.r = {{(LVL_W-1){1'b0}}, ch_on[2]};
                default: begin
                    nxt.r = {{(LVL_W-1){1'b0}}, ch_on[2]};
                    nxt.g = {{(LVL_W-1){1'b0}}, ch_on[1]};
                    nxt.b = {{(LVL_W-1){1'b0}}, ch_on[0]};
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_q     <= '0;
        end else begin
            out_valid <= pix_valid;
            out_q     <= nxt;
        end
    end

    assign out_r = out_q.r;
    assign out_g = out_q.g;
    assign out_b = out_q.b;

    // R9: valid follows the input one cycle later
    a_r9_valid_lag: assert property (@(posedge clk) disable iff (rst)
        out_valid == $past(pix_valid));
    // R9: no data without valid
    a_r9_idle_zero: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> (out_r == '0 && out_g == '0 && out_b == '0));
    // R6: TFT data passes unchanged
    a_r6_bypass: assert property (@(posedge clk) disable iff (rst)
        ($past(pix_valid) && $past(mode) == 2'd0) |->
        (out_r == $past(pix_r) && out_g == $past(pix_g) && out_b == $past(pix_b)));
    // R7: mono mode leaves green and blue dark
    a_r7_mono_gb: assert property (@(posedge clk) disable iff (rst)
        ($past(pix_valid) && $past(mode) == 2'd1) |->
        (out_g == '0 && out_b == '0 && out_r[LVL_W-1:1] == '0));
endmodule

// File: tb/test_stn_frc_dither.sv
module test_stn_frc_dither;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        frame_start = 1'b0;
    logic [1:0]  mode = 2'd1;
    logic        pat_wr_en = 1'b0;
    logic [3:0]  pat_wr_level = '0;
    logic [15:0] pat_wr_mask = '0;
    logic        pix_valid = 1'b0;
    logic [10:0] pix_x = '0;
    logic [3:0]  pix_r = '0, pix_g = '0, pix_b = '0;
    logic        out_valid;
    logic [3:0]  out_r, out_g, out_b;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    logic [15:0] m_sh [16];
    logic [15:0] m_act[16];
    int          m_frame;

    always #4 clk = ~clk;

    stn_frc_dither i_stn_frc_dither (
        .clk(clk), .rst(rst), .frame_start(frame_start), .mode(mode),
        .pat_wr_en(pat_wr_en), .pat_wr_level(pat_wr_level), .pat_wr_mask(pat_wr_mask),
        .pix_valid(pix_valid), .pix_x(pix_x), .pix_r(pix_r), .pix_g(pix_g), .pix_b(pix_b),
        .out_valid(out_valid), .out_r(out_r), .out_g(out_g), .out_b(out_b)
    );

    function automatic logic exp_bit(int lvl, int x);
        if (lvl == 0)  return 1'b0;
        if (lvl == 15) return 1'b1;
        return m_act[lvl][(m_frame + x) % 16];
    endfunction

    function automatic logic [12:0] exp_out(logic [1:0] md, int x, int r, int g, int b);
        case (md)
            2'd0:    return {1'b1, 4'(r), 4'(g), 4'(b)};
            2'd1:    return {1'b1, 3'b0, exp_bit(r, x), 8'h00};
            default: return {1'b1, 3'b0, exp_bit(r, x), 3'b0, exp_bit(g, x), 3'b0, exp_bit(b, x)};
        endcase
    endfunction

    task automatic chk(string req, logic [12:0] act, logic [12:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int l = 0; l < 16; l++) begin
            m_sh[l]  = 16'((32'd1 << l) - 1);
            m_act[l] = m_sh[l];
        end
        m_frame = 0;
    endtask

    task automatic frame_pulse();
        frame_start = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
        m_frame = (m_frame + 1) % 16;
        for (int l = 0; l < 16; l++) m_act[l] = m_sh[l];
    endtask

    task automatic write_pat(int lvl, logic [15:0] mask);
        pat_wr_en = 1'b1; pat_wr_level = 4'(lvl); pat_wr_mask = mask;
        @(negedge clk);
        pat_wr_en = 1'b0;
        m_sh[lvl] = mask;
    endtask

    task automatic pixel(string req, logic [1:0] md, int x, int r, int g, int b);
        logic [12:0] e;
        mode = md; pix_x = 11'(x); pix_r = 4'(r); pix_g = 4'(g); pix_b = 4'(b);
        pix_valid = 1'b1;
        e = exp_out(md, x, r, g, b);
        @(negedge clk);
        pix_valid = 1'b0;
        chk(req, {out_valid, out_r, out_g, out_b}, e);
    endtask

    initial begin
        void'($urandom(32'd7321));
        model_reset();
        repeat (3) @(negedge clk);
        chk("R1 reset", {out_valid, out_r, out_g, out_b}, 13'h0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 first cycle", {out_valid, out_r, out_g, out_b}, 13'h0);

        // R10 default masks: level 5 lit at phases 0..4
        pixel("R10 default on", 2'd1, 3, 5, 0, 0);
        pixel("R10 default off", 2'd1, 7, 5, 0, 0);
        @(negedge clk);
        chk("R9 idle", {out_valid, out_r, out_g, out_b}, 13'h0);

        // R3/R2: single-bit mask stepped through all phases and across the wrap
        write_pat(7, 16'h0001);
        frame_pulse();
        for (int f = 0; f < 18; f++) begin
            pixel("R3 phase x0", 2'd1, 0, 7, 0, 0);
            pixel("R3 phase x5", 2'd1, 5, 7, 0, 0);
            frame_pulse();
        end
        pixel("R2 wrapped x2047", 2'd1, 2047, 7, 0, 0);

        // R4: extreme levels against opposite masks
        write_pat(0, 16'hFFFF);
        write_pat(15, 16'h0000);
        frame_pulse();
        for (int x = 0; x < 4; x++) begin
            pixel("R4 level0 off", 2'd2, x, 0, 0, 0);
            pixel("R4 level15 on", 2'd2, x, 15, 15, 15);
        end

        // R5: write lands only at the next frame pulse
        write_pat(6, 16'h0000);
        for (int x = 0; x < 4; x++) pixel("R5 old mask before frame", 2'd1, x, 6, 0, 0);
        frame_pulse();
        for (int x = 0; x < 4; x++) pixel("R5 new mask after frame", 2'd1, x, 6, 0, 0);

        // R6, R7, R8 directed
        pixel("R6 bypass", 2'd0, 9, 4'hA, 4'h5, 4'hC);
        pixel("R7 mono ignores g/b", 2'd1, 1, 15, 15, 15);
        pixel("R8 colour independent", 2'd2, 2, 15, 0, 15);
        pixel("R8 colour mode 3", 2'd3, 2, 0, 15, 0);

        // random mix
        for (int i = 0; i < 3000; i++) begin
            int op;
            op = int'($urandom_range(0, 9));
            if (op == 0)      frame_pulse();
            else if (op == 1) write_pat(int'($urandom_range(0, 15)), 16'($urandom));
            else              pixel("R3 R6 R7 R8 random", 2'($urandom_range(0, 3)),
                                    int'($urandom_range(0, 2047)), int'($urandom_range(0, 15)),
                                    int'($urandom_range(0, 15)), int'($urandom_range(0, 15)));
        end
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule